// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Built-in Test Tone

This block turns a stream of 32-bit stereo PCM words into a three-wire serial audio bus: a bit clock, a word-select line and a serial data line, in the standard two-channel I2S timing. Words arrive on a valid/ready stream and wait in a small FIFO. In each word, bit 31 names the channel and bits 23..0 carry a 24-bit two's-complement sample. Every channel slot is 32 bit clocks long: 24 data bits, MSB first, followed by 8 zero bits. The bit-clock rate comes from a divisor input, and a constant output reports the system clock frequency so that software can work out a divisor.

A fault on the audio path can be narrowed down with an internal sine generator. It can feed the FIFO in place of the input stream, which isolates the memory side. It can also feed the serializer directly and bypass the FIFO, which isolates the FIFO. Back-pressure on the input follows the usual rules. A word transfers on a cycle where both `in_valid` and `in_ready` are high. `in_ready` falls when the FIFO is full, and it stays low for the whole time the tone feeds the FIFO. A word offered while `in_ready` is low stays at the input until it is taken.

Top module: `i2s_tx`

## Requirements
- R1: In a word, bit 31 is the channel (0 = left, 1 = right), bits 23..0 are the sample and bits 30..24 are ignored. Each 32-bit slot carries the sample MSB first in its first 24 bit clocks and zeros in the remaining 8.
- R2: `ws` is low during the left slot and high during the right slot. `ws` and `sd` change only on falling edges of `bclk`. The MSB of a slot appears one bit clock after `ws` changes. `ws` idles high, and the first slot after enable is a left slot.
- R3: Each half period of `bclk` lasts max(`divisor`,1) system clock cycles, so a divisor of 0 behaves like 1.
- R4: While `enable` is low, `bclk` and `sd` are held low, `ws` is held high and the frame position restarts.
- R5: The input is a valid/ready stream into a FIFO of FIFO_DEPTH words. Words leave in arrival order, and `in_ready` is low exactly when the FIFO is full or the pre-FIFO tone is selected.
- R6: If the head word's channel bit does not match the slot that is starting, the word is kept for later and the slot sends zeros.
- R7: If no word is available when a slot starts, the slot sends zeros and `underrun` sets. `underrun` stays set while `enable` is high, clears while `enable` is low, and is not set by a channel mismatch.
- R8: Tone sample k is round(2^22 x sin(2*pi*k/16)) as 24-bit two's complement. k starts at 0 when a tone mode becomes active, advances by one per stereo frame, and the same sample goes to both channels.
- R9: With `tone_post` high, the tone goes straight to the serializer, the FIFO keeps its contents and still accepts input. `tone_post` takes priority over `tone_pre`.
- R10: With only `tone_pre` high, the tone words are written into the FIFO and drained from it, and the FIFO never runs dry.
- R11: `clk_rate_hz` always reports the CLK_HZ parameter (50000000 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gates all bus activity |
| tone_pre | input | 1 | Tone feeds the FIFO |
| tone_post | input | 1 | Tone feeds the serializer directly |
| divisor | input | DIV_W | Bit-clock half period in system clocks |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | FIFO can take a word |
| in_data | input | 32 | Channel bit, reserved bits, 24-bit sample |
| clk_rate_hz | output | 32 | System clock frequency constant |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky empty-at-slot-start flag |

## Verification
The bench decodes the serial bus the way a receiver would and compares each slot against a queue of expected samples. A design that misplaced the one-bit offset after `ws` would shift every sample by a factor of two. A design that leaked the reserved bits would show non-zero padding. Runs start with a right-channel word at the head of the FIFO, which catches a design that sends the word into the wrong slot or counts the mismatch as an underrun. Divisors of 0, 1 and 3 expose an off-by-one half period. A post-FIFO tone run with words waiting in the FIFO, followed by a normal run, shows whether the bypass disturbs the FIFO. A long pre-FIFO run past the 16-step wrap checks the table symmetry and the once-per-frame stepping.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int WORD_W     = 32;
  localparam int CH_BIT     = 31;
  localparam int SAMPLE_W   = 24;
  localparam int PACKED_W   = SAMPLE_W + 1;
  localparam int TONE_IDX_W = 4;

  typedef enum logic [1:0] {
    SRC_FIFO      = 2'd0,
    SRC_TONE_PRE  = 2'd1,
    SRC_TONE_POST = 2'd2
  } src_sel_e;

  // 16-step sine built from five quarter-wave magnitudes (amplitude 2^22).
  function automatic logic [SAMPLE_W-1:0] tone_sample(input logic [TONE_IDX_W-1:0] idx);
    logic [2:0]          half_pos;
    logic [2:0]          quarter;
    logic [SAMPLE_W-1:0] mag;
    half_pos = idx[2:0];
    quarter  = (half_pos <= 3'd4) ? half_pos : (3'd0 - half_pos);
    case (quarter)
      3'd0:    mag = 24'd0;
      3'd1:    mag = 24'd1605091;
      3'd2:    mag = 24'd2965821;
      3'd3:    mag = 24'd3875032;
      default: mag = 24'd4194304;
    endcase
    return idx[3] ? (24'd0 - mag) : mag;
  endfunction
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_empty_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !in_valid) |=> (count == '0));
endmodule

// File: rtl/i2s_tx_tone.sv
module i2s_tx_tone import i2s_tx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PACKED_W-1:0] out_word
);
  logic [TONE_IDX_W-1:0] idx;
  logic                  ch;

  assign out_valid = active;
  assign out_word  = {ch, tone_sample(idx)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      ch  <= 1'b0;
    end else if (!active) begin
      idx <= '0;
      ch  <= 1'b0;
    end else if (out_valid && out_ready) begin
      ch <= ~ch;
      if (ch) idx <= idx + 1'b1;
    end
  end

  // A left word taken is followed by the right word with the same sample.
  assert_pair_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(out_valid && out_ready && !out_word[PACKED_W-1]))
      |-> (out_word[PACKED_W-1] && out_word[SAMPLE_W-1:0] == $past(out_word[SAMPLE_W-1:0])));
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer import i2s_tx_pkg::*; #(
  parameter int DIV_W  = 16,
  parameter int SLOT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                src_valid,
  input  logic [PACKED_W-1:0] src_word,
  output logic                src_pop,
  output logic                bclk,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int PAD_W      = SLOT_W - SAMPLE_W;

  logic [DIV_W-1:0]  div_eff, cnt;
  logic [POS_W-1:0]  pos, pos_next;
  logic [SLOT_W-1:0] shreg;
  logic              tick, fall_tick, slot_start, slot_ch;

  assign div_eff    = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick       = enable && (cnt >= div_eff - DIV_W'(1));
  assign fall_tick  = tick && bclk;
  assign pos_next   = pos + 1'b1;
  assign slot_start = (pos_next[POS_W-2:0] == '0);
  assign slot_ch    = pos_next[POS_W-1];
  assign src_pop    = fall_tick && slot_start && src_valid
                      && (src_word[PACKED_W-1] == slot_ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; bclk <= 1'b0; ws <= 1'b1; sd <= 1'b0;
      pos <= '1; shreg <= '0; underrun <= 1'b0;
    end else if (!enable) begin
      cnt <= '0; bclk <= 1'b0; ws <= 1'b1; sd <= 1'b0;
      pos <= '1; shreg <= '0; underrun <= 1'b0;
    end else begin
      if (tick) begin
        cnt  <= '0;
        bclk <= ~bclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (fall_tick) begin
        pos <= pos_next;
        ws  <= slot_ch;
        sd  <= shreg[SLOT_W-1];
        if (slot_start) begin
          shreg <= src_pop ? (SLOT_W'(src_word[SAMPLE_W-1:0]) << PAD_W) : '0;
          if (!src_valid) underrun <= 1'b1;
        end else begin
          shreg <= shreg << 1;
        end
      end
    end
  end

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk && !sd && ws));
  assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (ws != $past(ws))) |-> (!bclk && $past(bclk)));
  assert_sd_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (sd != $past(sd))) |-> (!bclk && $past(bclk)));
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(underrun)) |-> underrun);
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx import i2s_tx_pkg::*; #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int SLOT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tone_pre,
  input  logic              tone_post,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [31:0]       clk_rate_hz,
  output logic              bclk,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);
  src_sel_e            sel;
  logic                tone_active, tone_valid, tone_ready;
  logic [PACKED_W-1:0] tone_word;
  logic                f_in_valid, f_in_ready, f_out_valid, f_out_ready;
  logic [PACKED_W-1:0] f_in_data, f_out_data;
  logic                src_valid, src_pop;
  logic [PACKED_W-1:0] src_word;
  logic                unused_rsvd;

  assign sel = tone_post ? SRC_TONE_POST : (tone_pre ? SRC_TONE_PRE : SRC_FIFO);
  assign tone_active = enable && (sel != SRC_FIFO);
  assign clk_rate_hz = 32'(CLK_HZ);
  assign unused_rsvd = ^in_data[CH_BIT-1:SAMPLE_W];

  i2s_tx_tone u_tone (
    .clk, .rst_n, .active(tone_active),
    .out_valid(tone_valid), .out_ready(tone_ready), .out_word(tone_word)
  );

  assign f_in_valid = (sel == SRC_TONE_PRE) ? tone_valid : in_valid;
  assign f_in_data  = (sel == SRC_TONE_PRE) ? tone_word
                                            : {in_data[CH_BIT], in_data[SAMPLE_W-1:0]};
  assign in_ready   = (sel != SRC_TONE_PRE) && f_in_ready;

  i2s_tx_fifo #(.W(PACKED_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n,
    .in_valid(f_in_valid), .in_ready(f_in_ready), .in_data(f_in_data),
    .out_valid(f_out_valid), .out_ready(f_out_ready), .out_data(f_out_data)
  );

  assign src_valid   = (sel == SRC_TONE_POST) ? tone_valid : f_out_valid;
  assign src_word    = (sel == SRC_TONE_POST) ? tone_word  : f_out_data;
  assign f_out_ready = (sel != SRC_TONE_POST) && src_pop;
  assign tone_ready  = (sel == SRC_TONE_POST) ? src_pop
                     : (sel == SRC_TONE_PRE)  ? f_in_ready : 1'b0;

  i2s_tx_serializer #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_ser (
    .clk, .rst_n, .enable, .divisor,
    .src_valid, .src_word, .src_pop,
    .bclk, .ws, .sd, .underrun
  );

  assert_pop_has_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> src_valid);
  assert_post_keeps_fifo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_TONE_POST) |-> !f_out_ready);
endmodule

// File: tb/test_i2s_tx.sv
module test_i2s_tx;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0, tone_pre = 1'b0, tone_post = 1'b0;
  logic [DIV_W-1:0] divisor = '0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_data = '0;
  logic             in_ready, bclk, ws, sd, underrun;
  logic [31:0]      clk_rate_hz;

  always #4 clk = ~clk;

  i2s_tx i_i2s_tx (
    .clk, .rst_n, .enable, .tone_pre, .tone_post, .divisor,
    .in_valid, .in_ready, .in_data, .clk_rate_hz,
    .bclk, .ws, .sd, .underrun
  );

  int checks = 0, errors = 0;
  bit    q_ch[$];
  int    q_val[$];
  int    q_tol[$];
  string q_req[$];
  event  drained;

  task automatic chk(bit ok, string req, longint act, longint want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, want);
    end
  endtask

  function automatic int tone_ref(int k);
    real v;
    v = 4194304.0 * $sin(2.0 * 3.14159265358979 * real'(k % 16) / 16.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic expect_slot(bit ch, logic [23:0] d, string req);
    q_ch.push_back(ch); q_val.push_back(int'($signed(d)));
    q_tol.push_back(0); q_req.push_back(req);
  endtask

  task automatic expect_tone(int frames, string req);
    for (int k = 0; k < frames; k++) begin
      for (int c = 0; c < 2; c++) begin
        q_ch.push_back(c[0]); q_val.push_back(tone_ref(k));
        q_tol.push_back(2); q_req.push_back(req);
      end
    end
  endtask

  task automatic push_word(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drain();
    if (q_ch.size() != 0) @(drained);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Receiver-style monitor and bit-clock period meter.
  int          m_cnt = 40, since = 0, half_meas = 0;
  logic        m_prev_ws = 1'b1, m_prev_b = 1'b0, m_slot_ch = 1'b0, m_pad_ok = 1'b1;
  logic [23:0] m_acc = '0;

  always @(negedge clk) begin
    if (bclk != m_prev_b) begin half_meas = since; since = 1; end
    else since++;
    if (!rst_n || !enable) begin
      m_cnt = 40;
      m_prev_ws = 1'b1;
    end else if (bclk && !m_prev_b) begin
      if (ws != m_prev_ws) begin
        m_cnt = 0; m_acc = '0; m_pad_ok = 1'b1; m_slot_ch = ws;
      end else begin
        m_cnt++;
      end
      m_prev_ws = ws;
      if (m_cnt >= 1 && m_cnt <= 24) m_acc = {m_acc[22:0], sd};
      else if (m_cnt >= 25 && m_cnt <= 31 && sd) m_pad_ok = 1'b0;
      if (m_cnt == 31 && q_ch.size() != 0) begin
        bit    e_ch;
        int    e_val, e_tol, got, diff;
        string e_req;
        e_ch = q_ch.pop_front(); e_val = q_val.pop_front();
        e_tol = q_tol.pop_front(); e_req = q_req.pop_front();
        got  = int'($signed(m_acc));
        diff = (got > e_val) ? got - e_val : e_val - got;
        chk(m_slot_ch == e_ch, "R2 slot channel", m_slot_ch, e_ch);
        chk(diff <= e_tol, e_req, got, e_val);
        chk(m_pad_ok, "R1 zero padding", m_pad_ok, 1);
        if (q_ch.size() == 0) -> drained;
      end
    end
    m_prev_b = bclk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit moved;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(bclk == 1'b0, "R4 reset bclk", bclk, 0);
    chk(sd == 1'b0, "R4 reset sd", sd, 0);
    chk(ws == 1'b1, "R2 idle ws", ws, 1);
    chk(underrun == 1'b0, "R7 reset underrun", underrun, 0);
    chk(in_ready == 1'b1, "R5 reset ready", in_ready, 1);
    chk(clk_rate_hz == 32'd50000000, "R11 clock rate", clk_rate_hz, 50000000);
    moved = 1'b0;
    repeat (20) begin @(negedge clk); if (bclk || sd || !ws) moved = 1'b1; end
    chk(!moved, "R4 idle bus", moved, 0);

    // R1/R3/R7: normal data, divisor 3, reserved bits set
    divisor = 16'd3;
    push_word(32'h7F123456); expect_slot(1'b0, 24'h123456, "R1 left data");
    push_word(32'h80ABCDEF); expect_slot(1'b1, 24'hABCDEF, "R1 right data");
    push_word(32'h00800001); expect_slot(1'b0, 24'h800001, "R1 left data");
    push_word(32'hC5FFFFFF); expect_slot(1'b1, 24'hFFFFFF, "R1 reserved ignored");
    @(negedge clk) enable = 1'b1;
    wait_drain();
    chk(underrun == 1'b0, "R7 no early underrun", underrun, 0);
    repeat (400) @(negedge clk);
    chk(underrun == 1'b1, "R7 underrun after drain", underrun, 1);
    chk(half_meas == 3, "R3 half period div 3", half_meas, 3);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(underrun == 1'b0, "R7 clear when disabled", underrun, 0);
    chk(bclk == 1'b0 && ws == 1'b1, "R4 bus parked", {bclk, ws}, 1);

    // R5/R6: right word at head, then fill the FIFO
    divisor = 16'd1;
    push_word(32'h80000ABC); expect_slot(1'b0, 24'h0, "R6 mismatch sends zeros");
    expect_slot(1'b1, 24'h000ABC, "R6 held word");
    push_word(32'h00111111); expect_slot(1'b0, 24'h111111, "R5 order");
    push_word(32'h80222222); expect_slot(1'b1, 24'h222222, "R5 order");
    push_word(32'h00333333); expect_slot(1'b0, 24'h333333, "R5 order");
    push_word(32'h80444444); expect_slot(1'b1, 24'h444444, "R5 order");
    push_word(32'h00555555); expect_slot(1'b0, 24'h555555, "R5 order");
    push_word(32'h80666666); expect_slot(1'b1, 24'h666666, "R5 order");
    push_word(32'h00777777); expect_slot(1'b0, 24'h777777, "R5 order");
    chk(in_ready == 1'b0, "R5 full drops ready", in_ready, 0);
    @(negedge clk) enable = 1'b1;
    wait_drain();
    chk(underrun == 1'b0, "R7 mismatch is not underrun", underrun, 0);
    chk(half_meas == 1, "R3 half period div 1", half_meas, 1);
    @(negedge clk) enable = 1'b0;
    repeat (4) @(negedge clk);

    // R9: post-FIFO tone with words waiting, both tone bits set
    divisor = 16'd0;
    push_word(32'h000A0B0C);
    push_word(32'h800D0E0F);
    @(negedge clk) begin tone_post = 1'b1; tone_pre = 1'b1; end
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 post wins, input open", in_ready, 1);
    expect_tone(6, "R8 post tone sample");
    @(negedge clk) enable = 1'b1;
    wait_drain();
    chk(half_meas == 1, "R3 divisor 0 acts as 1", half_meas, 1);
    @(negedge clk) enable = 1'b0;
    @(negedge clk) begin tone_post = 1'b0; tone_pre = 1'b0; end
    expect_slot(1'b0, 24'h0A0B0C, "R9 FIFO kept left");
    expect_slot(1'b1, 24'h0D0E0F, "R9 FIFO kept right");
    @(negedge clk) enable = 1'b1;
    wait_drain();
    @(negedge clk) enable = 1'b0;
    repeat (4) @(negedge clk);

    // R10: pre-FIFO tone past the table wrap
    divisor = 16'd1;
    @(negedge clk) tone_pre = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 input blocked", in_ready, 0);
    expect_tone(18, "R8 pre tone sample");
    @(negedge clk) enable = 1'b1;
    wait_drain();
    chk(underrun == 1'b0, "R10 FIFO stays fed", underrun, 0);
    @(negedge clk) enable = 1'b0;
    @(negedge clk) tone_pre = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule